// File: doc/BRIEF.md
# Powerdown and Calibration Sequencer

This block sequences power-down and loop calibration for a clock recovery loop. Both are driven from one shared control pin. While the pin is high, the serial data and clock output drivers are turned off and the recovery loop is held idle. When the pin falls after a long enough high period, the control state is cleared and a calibration of the loop gain settings is started. The block then waits for the calibration engine to report completion. After that it enables the loop so it can acquire lock, and after a settling window it lets the loss-of-lock alarm through.

The pin is asynchronous and is brought into the controller clock through a two-stage synchronizer. The reference-clock-valid flag and the calibration-done handshake are synchronous to the controller clock. A calibration is never started while the reference clock is flagged invalid. If the reference is invalid when the pin is released, the request is held until the reference becomes valid. All pins are plain control or status levels, so there is no streaming interface and no back-pressure.

Top module: `pdcal_seq`

## Requirements
- R1: A rising pin level reaches the controller through two synchronizer stages. From any state, the output drivers are disabled on the third rising clock edge after the pin is seen high.
- R2: `drv_en` is low during power-down and high in every other state.
- R3: A release is qualified when the synchronized pin was high for at least `HOLD_CYCLES` controller cycles (default 50, which is 1 µs at 50 MHz). A qualified release with `ref_ok` high produces a `cal_start` pulse exactly one cycle wide, visible after the third rising edge following the pin's fall.
- R4: A release after fewer than `HOLD_CYCLES` high cycles returns the block to idle. Idle means drivers on, loop disabled and alarm masked, with no `cal_start`.
- R5: If `ref_ok` is low at a qualified release, the block waits. The `cal_start` pulse follows on the edge after `ref_ok` is sampled high.
- R6: If `ref_ok` drops while calibration runs, the block returns to waiting. When the reference is valid again, it issues a fresh `cal_start` pulse.
- R7: `cal_done` sampled high during calibration raises `loop_en` on that edge. `cal_done` in any other state has no effect.
- R8: `alarm_mask` is high in every state except run. The acquire phase keeps `loop_en` high and `alarm_mask` high for exactly `ACQ_CYCLES` cycles (default 16), then clears the mask.
- R9: When the synchronized pin rises in the same cycle that `cal_done` is sampled, power-down wins. The drivers and the loop both end up disabled.
- R10: After reset the block is idle: `drv_en`=1, `loop_en`=0, `cal_start`=0, `alarm_mask`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_pin | input | 1 | Shared power-down / calibrate pin, asynchronous |
| ref_ok | input | 1 | Reference clock valid flag |
| cal_done | input | 1 | Calibration engine finished |
| drv_en | output | 1 | Serial output driver enable |
| cal_start | output | 1 | One-cycle calibration start pulse |
| loop_en | output | 1 | Recovery loop enable |
| alarm_mask | output | 1 | Suppresses the loss-of-lock alarm |

## Verification
Two events can land on the same edge. One is completion of calibration, reported by `cal_done`. The other is a new power-down request, which is the synchronized pin rising. The bench raises the pin while calibration is running and times `cal_done` to be sampled on exactly the edge at which the synchronized pin is first seen high. The result is judged correct only if the drivers and the loop are both off after that edge. The bench also probes the hold-time boundary: one release at exactly `HOLD_CYCLES` high cycles and one release a single cycle short of it.

// File: rtl/pdcal_pkg.sv
package pdcal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_OFF      = 3'd1,
    ST_WAIT_REF = 3'd2,
    ST_CAL      = 3'd3,
    ST_ACQ      = 3'd4,
    ST_RUN      = 3'd5
  } pdc_state_e;

endpackage

// File: rtl/pdcal_sync.sv
module pdcal_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= d_async;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/pdcal_hold_timer.sv
module pdcal_hold_timer #(
  parameter int HOLD_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic hold_met
);

  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!level)       cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign hold_met = (cnt == LIMIT);

  AST_HOLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (level && hold_met) |=> hold_met); // R3

  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !level |=> !hold_met); // R4

endmodule

// File: rtl/pdcal_fsm.sv
module pdcal_fsm
  import pdcal_pkg::*;
#(
  parameter int ACQ_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic hold_met,
  input  logic ref_ok,
  input  logic cal_done,
  output logic drv_en,
  output logic cal_start,
  output logic loop_en,
  output logic alarm_mask
);

  localparam int AW = (ACQ_CYCLES > 1) ? $clog2(ACQ_CYCLES) : 1;
  localparam logic [AW-1:0] ACQ_LAST = AW'(ACQ_CYCLES - 1);

  pdc_state_e st, nxt;
  logic [AW-1:0] acq_cnt;
  logic acq_last;
  logic start_q;

  assign acq_last = (acq_cnt == ACQ_LAST);

  always_comb begin
    nxt = st;
    if (pin_s) begin
      nxt = ST_OFF;
    end else begin
      unique case (st)
        ST_IDLE:     nxt = ST_IDLE;
        ST_OFF:      nxt = hold_met ? (ref_ok ? ST_CAL : ST_WAIT_REF) : ST_IDLE;
        ST_WAIT_REF: nxt = ref_ok ? ST_CAL : ST_WAIT_REF;
        ST_CAL: begin
          if (!ref_ok)      nxt = ST_WAIT_REF;
          else if (cal_done) nxt = ST_ACQ;
        end
        ST_ACQ:      nxt = acq_last ? ST_RUN : ST_ACQ;
        ST_RUN:      nxt = ST_RUN;
        default:     nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      start_q <= 1'b0;
      acq_cnt <= '0;
    end else begin
      st      <= nxt;
      start_q <= (nxt == ST_CAL) && (st != ST_CAL);
      if (st == ST_ACQ && nxt == ST_ACQ) acq_cnt <= acq_cnt + 1'b1;
      else                               acq_cnt <= '0;
    end
  end

  assign drv_en     = (st != ST_OFF);
  assign loop_en    = (st == ST_ACQ) || (st == ST_RUN);
  assign alarm_mask = (st != ST_RUN);
  assign cal_start  = start_q;

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> !cal_start); // R3

  AST_START_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_start) |-> $past(ref_ok)); // R5

  AST_SHORT_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_en && !pin_s && !hold_met) |=> !cal_start); // R4

  AST_PIN_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    pin_s |=> (!drv_en && !loop_en && alarm_mask)); // R1

  AST_LOOP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_en) |-> ($past(cal_done) && $past(ref_ok))); // R7

  AST_ALARM_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |-> alarm_mask); // R8

endmodule

// File: rtl/pdcal_seq.sv
module pdcal_seq #(
  parameter int HOLD_CYCLES = 50,
  parameter int ACQ_CYCLES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_pin,
  input  logic ref_ok,
  input  logic cal_done,
  output logic drv_en,
  output logic cal_start,
  output logic loop_en,
  output logic alarm_mask
);

  logic pin_s;
  logic hold_met;

  pdcal_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pd_pin),
    .q_sync  (pin_s)
  );

  pdcal_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) i_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (pin_s),
    .hold_met (hold_met)
  );

  pdcal_fsm #(.ACQ_CYCLES(ACQ_CYCLES)) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_s      (pin_s),
    .hold_met   (hold_met),
    .ref_ok     (ref_ok),
    .cal_done   (cal_done),
    .drv_en     (drv_en),
    .cal_start  (cal_start),
    .loop_en    (loop_en),
    .alarm_mask (alarm_mask)
  );

endmodule

// File: tb/test_pdcal_seq.sv
`timescale 1ns/1ps
module test_pdcal_seq;

  localparam int HOLD = 50;
  localparam int ACQ  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_pin = 1'b0;
  logic ref_ok = 1'b1;
  logic cal_done = 1'b0;
  logic drv_en, cal_start, loop_en, alarm_mask;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pdcal_seq #(.HOLD_CYCLES(HOLD), .ACQ_CYCLES(ACQ)) i_pdcal_seq (
    .clk(clk), .rst_n(rst_n), .pd_pin(pd_pin), .ref_ok(ref_ok),
    .cal_done(cal_done), .drv_en(drv_en), .cal_start(cal_start),
    .loop_en(loop_en), .alarm_mask(alarm_mask)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic check_outs(input string req, input logic d, input logic s, input logic l, input logic m);
    check(req, "drv_en", drv_en, d);
    check(req, "cal_start", cal_start, s);
    check(req, "loop_en", loop_en, l);
    check(req, "alarm_mask", alarm_mask, m);
  endtask

  // Hold pin high for p cycles, then release; returns at the release negedge.
  task automatic pulse_pin(input int p);
    pd_pin = 1'b1;
    tick(p);
    pd_pin = 1'b0;
  endtask

  task automatic t_reset;
    check_outs("R10", 1'b1, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_full_sequence;
    ref_ok = 1'b1;
    pd_pin = 1'b1;
    tick(2);
    check("R1", "drv_en before sync", drv_en, 1'b1);
    tick(1);
    check("R1", "drv_en after 3 edges", drv_en, 1'b0);
    check("R2", "alarm_mask in power-down", alarm_mask, 1'b1);
    tick(HOLD);
    pd_pin = 1'b0;
    tick(2);
    check_outs("R2", 1'b0, 1'b0, 1'b0, 1'b1);
    tick(1);
    check_outs("R3", 1'b1, 1'b1, 1'b0, 1'b1);
    tick(1);
    check("R3", "cal_start one cycle", cal_start, 1'b0);
    tick(3);
    check("R7", "loop_en waits for done", loop_en, 1'b0);
    cal_done = 1'b1;
    tick(1);
    cal_done = 1'b0;
    check("R7", "loop_en after done", loop_en, 1'b1);
    check("R8", "mask in acquire", alarm_mask, 1'b1);
    tick(ACQ - 1);
    check("R8", "mask at end of acquire", alarm_mask, 1'b1);
    tick(1);
    check("R8", "mask cleared in run", alarm_mask, 1'b0);
    check("R8", "loop_en in run", loop_en, 1'b1);
  endtask

  task automatic t_powerdown_from_run;
    pd_pin = 1'b1;
    tick(3);
    check_outs("R1", 1'b0, 1'b0, 1'b0, 1'b1);
    tick(10);
    pd_pin = 1'b0;
    tick(4);
    check_outs("R4", 1'b1, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_short_pulse;
    bit seen = 1'b0;
    pulse_pin(HOLD - 1);
    for (int i = 0; i < 8; i++) begin
      tick(1);
      if (cal_start) seen = 1'b1;
    end
    check("R4", "no cal_start on short high", seen, 1'b0);
    check_outs("R4", 1'b1, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_exact_boundary;
    pulse_pin(HOLD);
    tick(3);
    check("R3", "cal_start at exact hold", cal_start, 1'b1);
  endtask

  task automatic t_ref_pending;
    ref_ok = 1'b0;
    pulse_pin(HOLD + 5);
    tick(3);
    check_outs("R5", 1'b1, 1'b0, 1'b0, 1'b1);
    tick(6);
    check("R5", "still waiting", cal_start, 1'b0);
    cal_done = 1'b1;
    tick(1);
    cal_done = 1'b0;
    check("R7", "done ignored while waiting", loop_en, 1'b0);
    ref_ok = 1'b1;
    tick(1);
    check("R5", "cal_start after ref valid", cal_start, 1'b1);
  endtask

  task automatic t_ref_loss;
    // in calibration from previous task
    tick(2);
    ref_ok = 1'b0;
    tick(1);
    check("R6", "no start while ref lost", cal_start, 1'b0);
    cal_done = 1'b1;
    tick(1);
    cal_done = 1'b0;
    check("R6", "done ignored after ref loss", loop_en, 1'b0);
    ref_ok = 1'b1;
    tick(1);
    check("R6", "fresh cal_start", cal_start, 1'b1);
  endtask

  task automatic t_idle_done_ignored;
    pulse_pin(5);
    tick(4);
    cal_done = 1'b1;
    tick(2);
    cal_done = 1'b0;
    check_outs("R7", 1'b1, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_collision;
    ref_ok = 1'b1;
    pulse_pin(HOLD);
    tick(3);
    check("R9", "in calibration", cal_start, 1'b1);
    tick(2);
    pd_pin = 1'b1;
    tick(2);
    cal_done = 1'b1;
    tick(1);
    cal_done = 1'b0;
    check("R9", "drv_en off on collision", drv_en, 1'b0);
    check("R9", "loop_en off on collision", loop_en, 1'b0);
    tick(1);
    check("R9", "loop_en stays off", loop_en, 1'b0);
    pd_pin = 1'b0;
    tick(4);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_full_sequence();
    t_powerdown_from_run();
    t_short_pulse();
    t_exact_boundary();
    t_ref_pending();
    t_ref_loss();
    t_idle_done_ignored();
    t_collision();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule